// File: doc/BRIEF.md
# Adaptive Private/Remote Sharer Mode Classifier

This block is the decision engine that sits next to a shared-cache directory entry for one cache line. For each tracked sharer it holds three small fields: a mode bit (private or remote), a saturating remote-use counter and a promotion-threshold level. When a sharer misses in its private cache and its request reaches the shared cache, the block decides whether the sharer receives a full copy of the line (read-only or read-write) or whether only the one requested word is read or written at the shared cache.

When a private sharer gives up its copy, either through an eviction or through an invalidation, the acknowledgement carries the number of times the copy was used. The block then classifies the sharer again. Heavy use keeps it private. Light use makes it remote. An eviction that leads to demotion also makes the next promotion harder. A write from any core wipes the remote-use history of every other sharer. A line fill from memory puts every sharer back into private mode. Each request or acknowledgement yields a one-cycle decision strobe. The strobe carries the grant type and the sharer's updated fields, so the directory can store them or forward them.

Top module: `locality_mode_classifier`

## Requirements
- R1: After reset, and in the cycle after `fill_valid`, every sharer is private (mode bit 0) with a remote-use counter of 0 and a threshold level of 0. A fill produces no strobe.
- R2: A request from a private sharer gets grant code 2 (line, read-only) for a read or 3 (line, read-write) for a write. The sharer's own fields stay unchanged.
- R3: A request from a remote sharer (mode bit 1) whose incremented use count stays below the active threshold gets grant code 1 (word). The sharer's counter becomes the incremented count.
- R4: The active threshold is PCT + level × (RAT_MAX − PCT)/(RAT_LEVELS − 1). With the defaults, level 0 means 4 and level 1 means 16. When the incremented count of a remote sharer reaches the threshold, the sharer becomes private and its counter resets to 0. It gets grant code 2 or 3. Its level is kept.
- R5: When `req_inv_way` is set, a remote sharer is promoted once its incremented count is at least PCT, whatever its level.
- R6: On an acknowledgement for a private sharer, if `ack_util` plus the stored counter is at least PCT, the sharer stays private and its level returns to 0. Otherwise its mode bit becomes 1.
- R7: A demotion caused by an eviction (`ack_evict` = 1) raises the level by one, saturating at RAT_LEVELS − 1. A demotion caused by an invalidation (`ack_evict` = 0) leaves the level unchanged.
- R8: A write request clears the remote-use counter of every sharer other than the requester. The requester's own counter follows R2 to R5.
- R9: The remote-use counter saturates at 2^UTIL_W − 1 and never wraps.
- R10: An acknowledgement naming a sharer that is already remote changes nothing. Its strobe reports grant code 0 (none) and the unchanged fields.
- R11: The strobe `dec_valid` rises in the cycle after an accepted request or acknowledgement and lasts one cycle per event. `dec_id` echoes the sharer, and the field outputs give that sharer's state after the update.
- R12: Priority runs fill, then request, then acknowledgement. An event that arrives in the same cycle as a higher-priority one is dropped with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | Line newly fetched from memory; all sharers private |
| req_valid | input | 1 | Shared-cache request from a sharer |
| req_id | input | ID_W | Requesting sharer index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_inv_way | input | 1 | Requester's private set holds an invalid way |
| ack_valid | input | 1 | Eviction/invalidation acknowledgement |
| ack_id | input | ID_W | Acknowledging sharer index |
| ack_evict | input | 1 | 1 = eviction, 0 = invalidation |
| ack_util | input | PUTIL_W | Private use count reported with the acknowledgement |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_grant | output | 2 | 0 none, 1 word, 2 line read-only, 3 line read-write |
| dec_id | output | ID_W | Sharer the decision refers to |
| dec_mode | output | 1 | Updated mode: 0 private, 1 remote |
| dec_rutil | output | UTIL_W | Updated remote-use counter |
| dec_lvl | output | LVL_W | Updated threshold level |

## Verification
The hardest states to reach are the high threshold level and the saturated counter. Reaching the high level takes a fill, then an eviction acknowledgement with low use, then fifteen word accesses before the promotion at sixteen. A saturated counter only shows up when the top threshold is above the counter's range. A second instance therefore uses a top threshold of 40 and takes twenty reads that must stay at 15, followed by an invalid-way read that must promote. The cleared counters of other sharers cannot be read directly. The bench exposes them by sending an acknowledgement to a sharer that is already remote, which echoes that sharer's fields without changing them. Sweeps over every sharer and every reported use count, plus a long stretch of mixed traffic, are compared against an arithmetic model.

// File: rtl/lmc_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the sharer mode classifier.
// Assumes: mode bit 0 = private, 1 = remote; grant codes are fixed.
package lmc_pkg;

    localparam logic MODE_PRIV   = 1'b0;
    localparam logic MODE_REMOTE = 1'b1;

    typedef enum logic [1:0] {
        GR_NONE    = 2'd0,
        GR_WORD    = 2'd1,
        GR_LINE_RO = 2'd2,
        GR_LINE_RW = 2'd3
    } grant_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lmc_threshold.sv
`timescale 1ns/1ps
// Module: lmc_threshold
// Works out the promotion threshold that applies to one remote sharer.
// The threshold comes from its level, or is PCT when the requester reports
// an invalid way. Assumes RAT_MAX >= PCT. A level above the top one is
// treated as RAT_MAX.
module lmc_threshold #(
    parameter int PCT        = 4,
    parameter int RAT_MAX    = 16,
    parameter int RAT_LEVELS = 2,
    parameter int LVL_W      = 1,
    parameter int CMP_W      = 9
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic             inv_way,
    output logic [CMP_W-1:0] thresh
);
    localparam int RAT_STEP = (RAT_LEVELS > 1) ? (RAT_MAX - PCT) / (RAT_LEVELS - 1) : 0;
    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(RAT_LEVELS - 1);

    logic [CMP_W-1:0] lvl_th;

    generate
        if (RAT_LEVELS == 1) begin : g_single
            // Single level: the threshold never moves.
            assign lvl_th = CMP_W'(PCT);
        end else begin : g_multi
            // Additive steps from PCT toward RAT_MAX.
            always_comb begin
                if (lvl > LVL_TOP)
                    lvl_th = CMP_W'(RAT_MAX);
                else
                    lvl_th = CMP_W'(PCT) + CMP_W'(lvl) * CMP_W'(RAT_STEP);
            end
        end
    endgenerate

    // Invalid-way shortcut replaces the level threshold with PCT.
    always_comb begin
        thresh = inv_way ? CMP_W'(PCT) : lvl_th;
    end

    // R4: a level threshold stays between PCT and RAT_MAX
    always_comb begin
        th_range_chk: assert (lvl_th >= CMP_W'(PCT) && lvl_th <= CMP_W'(RAT_MAX) || $isunknown(lvl))
            else $error("threshold out of range");
    end
endmodule

// File: rtl/lmc_decide.sv
`timescale 1ns/1ps
// Module: lmc_decide
// Combinational next-state and grant logic for the single sharer named by
// the current event. Assumes that at most one of is_req/is_ack is set, and
// that thresh comes from lmc_threshold for this sharer's level.
module lmc_decide
    import lmc_pkg::*;
#(
    parameter int PCT        = 4,
    parameter int RAT_LEVELS = 2,
    parameter int UTIL_W     = 4,
    parameter int PUTIL_W    = 8,
    parameter int LVL_W      = 1,
    parameter int CMP_W      = 9
) (
    input  logic               is_req,
    input  logic               is_ack,
    input  logic               req_write,
    input  logic               ack_evict,
    input  logic [PUTIL_W-1:0] ack_util,
    input  logic [CMP_W-1:0]   thresh,
    input  logic               cur_mode,
    input  logic [UTIL_W-1:0]  cur_rutil,
    input  logic [LVL_W-1:0]   cur_lvl,
    output logic               nxt_mode,
    output logic [UTIL_W-1:0]  nxt_rutil,
    output logic [LVL_W-1:0]   nxt_lvl,
    output grant_e             grant
);
    localparam logic [CMP_W-1:0] UMAX    = CMP_W'((1 << UTIL_W) - 1);
    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(RAT_LEVELS - 1);

    logic [CMP_W-1:0] cnt_inc;
    logic [CMP_W-1:0] use_sum;
    grant_e           line_gr;

    // Count seen by this access, held wide enough to reach the threshold.
    always_comb begin
        cnt_inc = CMP_W'(cur_rutil) + CMP_W'(1);
        use_sum = CMP_W'(ack_util) + CMP_W'(cur_rutil);
        line_gr = req_write ? GR_LINE_RW : GR_LINE_RO;
    end

    // Decide the grant and the sharer's next fields.
    always_comb begin
        nxt_mode  = cur_mode;
        nxt_rutil = cur_rutil;
        nxt_lvl   = cur_lvl;
        grant     = GR_NONE;
        if (is_req) begin
            if (cur_mode == MODE_PRIV) begin
                grant = line_gr;
            end else if (cnt_inc >= thresh) begin
                nxt_mode  = MODE_PRIV;
                nxt_rutil = '0;
                grant     = line_gr;
            end else begin
                grant     = GR_WORD;
                nxt_rutil = (cnt_inc > UMAX) ? UMAX[UTIL_W-1:0] : cnt_inc[UTIL_W-1:0];
            end
        end else if (is_ack && cur_mode == MODE_PRIV) begin
            if (use_sum >= CMP_W'(PCT)) begin
                nxt_lvl = '0;
            end else begin
                nxt_mode = MODE_REMOTE;
                if (ack_evict && cur_lvl < LVL_TOP)
                    nxt_lvl = cur_lvl + 1'b1;
            end
        end
    end

    // R3: a word grant is only issued to a sharer that remains remote
    always_comb begin
        word_mode_chk: assert (grant != GR_WORD || nxt_mode == MODE_REMOTE)
            else $error("word grant with private mode");
    end
endmodule

// File: rtl/lmc_entry.sv
`timescale 1ns/1ps
// Module: lmc_entry
// State of one tracked sharer: mode, remote-use counter and threshold level.
// Assumes that upd_en and clr_util are never set together for one entry.
// Fill wins over both.
module lmc_entry
    import lmc_pkg::*;
#(
    parameter int UTIL_W     = 4,
    parameter int LVL_W      = 1,
    parameter int RAT_LEVELS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic              upd_en,
    input  logic              clr_util,
    input  logic              upd_mode,
    input  logic [UTIL_W-1:0] upd_rutil,
    input  logic [LVL_W-1:0]  upd_lvl,
    output logic              mode_q,
    output logic [UTIL_W-1:0] rutil_q,
    output logic [LVL_W-1:0]  lvl_q
);
    // Hold the sharer's fields; reset and fill return it to private.
    always_ff @(posedge clk) begin
        if (!rst_n || fill) begin
            mode_q  <= MODE_PRIV;
            rutil_q <= '0;
            lvl_q   <= '0;
        end else if (upd_en) begin
            mode_q  <= upd_mode;
            rutil_q <= upd_rutil;
            lvl_q   <= upd_lvl;
        end else if (clr_util) begin
            rutil_q <= '0;
        end
    end

    // R1
    fill_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> (mode_q == MODE_PRIV && rutil_q == '0 && lvl_q == '0))
        else $error("fill did not restore private state");

    // R4
    promote_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q) |-> (rutil_q == '0))
        else $error("promotion kept a nonzero counter");

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rutil_q >= $past(rutil_q) || rutil_q == '0))
        else $error("remote counter wrapped or shrank");

    // R7
    lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(lvl_q) < RAT_LEVELS)
        else $error("level beyond top");

    // R7
    lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_q == $past(lvl_q) || lvl_q == '0 || lvl_q == $past(lvl_q) + 1'b1))
        else $error("level jumped");
endmodule

// File: rtl/locality_mode_classifier.sv
`timescale 1ns/1ps
// Module: locality_mode_classifier
// Per-line private/remote classifier for NUM_SHARERS tracked sharers.
// Picks one event per cycle (fill, then request, then acknowledgement),
// updates the named sharer, and reports a registered decision strobe one
// cycle later. Assumes ids below NUM_SHARERS.
module locality_mode_classifier
    import lmc_pkg::*;
#(
    parameter int NUM_SHARERS = 4,
    parameter int UTIL_W      = 4,
    parameter int PUTIL_W     = 8,
    parameter int PCT         = 4,
    parameter int RAT_MAX     = 16,
    parameter int RAT_LEVELS  = 2,
    localparam int ID_W  = (NUM_SHARERS > 1) ? $clog2(NUM_SHARERS) : 1,
    localparam int LVL_W = (RAT_LEVELS > 1) ? $clog2(RAT_LEVELS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic               req_valid,
    input  logic [ID_W-1:0]    req_id,
    input  logic               req_write,
    input  logic               req_inv_way,
    input  logic               ack_valid,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               ack_evict,
    input  logic [PUTIL_W-1:0] ack_util,
    output logic               dec_valid,
    output logic [1:0]         dec_grant,
    output logic [ID_W-1:0]    dec_id,
    output logic               dec_mode,
    output logic [UTIL_W-1:0]  dec_rutil,
    output logic [LVL_W-1:0]   dec_lvl
);
    localparam int TH_W  = $clog2(RAT_MAX + 1);
    localparam int CMP_W = imax(imax(UTIL_W, PUTIL_W), TH_W) + 1;

    logic              req_act, ack_act;
    logic [ID_W-1:0]   sel_id;
    logic              mode_a  [NUM_SHARERS];
    logic [UTIL_W-1:0] rutil_a [NUM_SHARERS];
    logic [LVL_W-1:0]  lvl_a   [NUM_SHARERS];
    logic              cur_mode;
    logic [UTIL_W-1:0] cur_rutil;
    logic [LVL_W-1:0]  cur_lvl;
    logic [CMP_W-1:0]  thresh;
    logic              nxt_mode;
    logic [UTIL_W-1:0] nxt_rutil;
    logic [LVL_W-1:0]  nxt_lvl;
    grant_e            grant;

    // Event arbitration: fill beats request beats acknowledgement.
    always_comb begin
        req_act = req_valid && !fill_valid;
        ack_act = ack_valid && !fill_valid && !req_valid;
        sel_id  = req_act ? req_id : ack_id;
    end

    // Fetch the fields of the sharer named by the winning event.
    always_comb begin
        cur_mode  = mode_a[sel_id];
        cur_rutil = rutil_a[sel_id];
        cur_lvl   = lvl_a[sel_id];
    end

    lmc_threshold #(
        .PCT(PCT), .RAT_MAX(RAT_MAX), .RAT_LEVELS(RAT_LEVELS),
        .LVL_W(LVL_W), .CMP_W(CMP_W)
    ) u_thresh (
        .lvl(cur_lvl), .inv_way(req_inv_way && req_act), .thresh(thresh)
    );

    lmc_decide #(
        .PCT(PCT), .RAT_LEVELS(RAT_LEVELS), .UTIL_W(UTIL_W),
        .PUTIL_W(PUTIL_W), .LVL_W(LVL_W), .CMP_W(CMP_W)
    ) u_decide (
        .is_req(req_act), .is_ack(ack_act), .req_write(req_write),
        .ack_evict(ack_evict), .ack_util(ack_util), .thresh(thresh),
        .cur_mode(cur_mode), .cur_rutil(cur_rutil), .cur_lvl(cur_lvl),
        .nxt_mode(nxt_mode), .nxt_rutil(nxt_rutil), .nxt_lvl(nxt_lvl),
        .grant(grant)
    );

    generate
        for (genvar g = 0; g < NUM_SHARERS; g++) begin : g_ent
            logic hit, clr;
            // Decode whether this sharer is updated or only has its counter cleared.
            always_comb begin
                hit = (req_act || ack_act) && (sel_id == ID_W'(g));
                clr = req_act && req_write && (req_id != ID_W'(g));
            end

            lmc_entry #(
                .UTIL_W(UTIL_W), .LVL_W(LVL_W), .RAT_LEVELS(RAT_LEVELS)
            ) u_ent (
                .clk(clk), .rst_n(rst_n), .fill(fill_valid),
                .upd_en(hit), .clr_util(clr),
                .upd_mode(nxt_mode), .upd_rutil(nxt_rutil), .upd_lvl(nxt_lvl),
                .mode_q(mode_a[g]), .rutil_q(rutil_a[g]), .lvl_q(lvl_a[g])
            );

            // R8
            wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_act && req_write && req_id != ID_W'(g)) |=> (rutil_a[g] == '0))
                else $error("write left another counter set");
        end
    endgenerate

    // Register the decision strobe and the updated fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_grant <= GR_NONE;
            dec_id    <= '0;
            dec_mode  <= MODE_PRIV;
            dec_rutil <= '0;
            dec_lvl   <= '0;
        end else begin
            dec_valid <= req_act || ack_act;
            dec_grant <= grant;
            dec_id    <= sel_id;
            dec_mode  <= nxt_mode;
            dec_rutil <= nxt_rutil;
            dec_lvl   <= nxt_lvl;
        end
    end

    // R2
    line_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_grant[1]) |-> (dec_mode == MODE_PRIV))
        else $error("line grant to a remote sharer");

    // R12
    fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !dec_valid)
        else $error("strobe after fill");

    // R10
    remote_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_act && cur_mode == MODE_REMOTE) |=>
            (dec_grant == GR_NONE && dec_mode == MODE_REMOTE &&
             dec_rutil == $past(cur_rutil) && dec_lvl == $past(cur_lvl)))
        else $error("ack changed a remote sharer");

    // R6
    stay_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_act && cur_mode == MODE_PRIV && CMP_W'(ack_util) >= CMP_W'(PCT)) |=>
            (dec_mode == MODE_PRIV && dec_lvl == '0))
        else $error("well-used sharer demoted");

    // R11
    strobe_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_act |=> (dec_valid && dec_id == $past(req_id)))
        else $error("strobe missing or wrong id");
endmodule

// File: tb/locality_mode_classifier_tb.sv
`timescale 1ns/1ps
module locality_mode_classifier_tb;
    localparam int NS = 4, PCT = 4, UMAX = 15, STEP = 12, LTOP = 1;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       fill_valid = 0, req_valid = 0, req_write = 0, req_inv_way = 0;
    logic       ack_valid = 0, ack_evict = 0;
    logic [1:0] req_id = 0, ack_id = 0;
    logic [7:0] ack_util = 0;
    logic       dec_valid, dec_mode, s_valid, s_mode;
    logic [1:0] dec_grant, dec_id, s_grant, s_id;
    logic [3:0] dec_rutil, s_rutil;
    logic       dec_lvl, s_lvl;

    int n_chk = 0, n_fail = 0;
    int m_mode[NS], m_rutil[NS], m_lvl[NS];

    always #5 clk = ~clk;

    locality_mode_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .req_valid(req_valid),
        .req_id(req_id), .req_write(req_write), .req_inv_way(req_inv_way),
        .ack_valid(ack_valid), .ack_id(ack_id), .ack_evict(ack_evict), .ack_util(ack_util),
        .dec_valid(dec_valid), .dec_grant(dec_grant), .dec_id(dec_id),
        .dec_mode(dec_mode), .dec_rutil(dec_rutil), .dec_lvl(dec_lvl));

    // Second copy with a top threshold above the counter range (R9).
    locality_mode_classifier #(.RAT_MAX(40)) u_sat (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .req_valid(req_valid),
        .req_id(req_id), .req_write(req_write), .req_inv_way(req_inv_way),
        .ack_valid(ack_valid), .ack_id(ack_id), .ack_evict(ack_evict), .ack_util(ack_util),
        .dec_valid(s_valid), .dec_grant(s_grant), .dec_id(s_id),
        .dec_mode(s_mode), .dec_rutil(s_rutil), .dec_lvl(s_lvl));

    function automatic int pk(int v, int g, int id, int m, int ru, int lv);
        return (v << 10) | (g << 8) | (id << 6) | (m << 5) | (ru << 1) | lv;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, sample just after posedge, release (R11 timing).
    task automatic cyc(input bit f, input bit rv, input int rid, input bit rw, input bit iw,
                       input bit av, input int aid, input bit ae, input int au);
        @(negedge clk);
        fill_valid = f; req_valid = rv; req_id = 2'(rid); req_write = rw; req_inv_way = iw;
        ack_valid = av; ack_id = 2'(aid); ack_evict = ae; ack_util = 8'(au);
        @(posedge clk);
        #1;
        fill_valid = 0; req_valid = 0; ack_valid = 0;
    endtask

    function automatic int dut_pk();
        return pk(int'(dec_valid), int'(dec_grant), int'(dec_id), int'(dec_mode),
                  int'(dec_rutil), int'(dec_lvl));
    endfunction

    task automatic model_fill();
        for (int i = 0; i < NS; i++) begin m_mode[i] = 0; m_rutil[i] = 0; m_lvl[i] = 0; end
    endtask

    // Model of a request; returns expected packed strobe and a tag.
    task automatic model_req(input int id, input bit wr, input bit iw,
                             output int exp, output string tag);
        int g, cnt, th;
        g = wr ? 3 : 2;
        tag = "R2";
        if (m_mode[id] == 1) begin
            cnt = m_rutil[id] + 1;
            th = iw ? PCT : PCT + m_lvl[id] * STEP;
            if (cnt >= th) begin
                m_mode[id] = 0; m_rutil[id] = 0; tag = iw ? "R5" : "R4";
            end else begin
                g = 1; m_rutil[id] = (cnt > UMAX) ? UMAX : cnt; tag = "R3";
            end
        end
        if (wr) begin
            for (int i = 0; i < NS; i++) if (i != id) m_rutil[i] = 0;
            tag = {tag, "/R8"};
        end
        exp = pk(1, g, id, m_mode[id], m_rutil[id], m_lvl[id]);
    endtask

    task automatic op_req(input int id, input bit wr, input bit iw);
        int exp; string tag;
        cyc(0, 1, id, wr, iw, 0, 0, 0, 0);
        model_req(id, wr, iw, exp, tag);
        check(tag, dut_pk(), exp);
    endtask

    task automatic op_ack(input int id, input int u, input bit ev);
        string tag;
        cyc(0, 0, 0, 0, 0, 1, id, ev, u);
        if (m_mode[id] == 1) tag = "R10";
        else if (u + m_rutil[id] >= PCT) begin m_lvl[id] = 0; tag = "R6"; end
        else begin
            m_mode[id] = 1; tag = "R6/R7";
            if (ev && m_lvl[id] < LTOP) m_lvl[id]++;
        end
        check(tag, dut_pk(), pk(1, 0, id, m_mode[id], m_rutil[id], m_lvl[id]));
    endtask

    task automatic op_fill();
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        model_fill();
        check("R1 fill no strobe", int'(dec_valid), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int exp; string tag;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset strobe low", int'(dec_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        model_fill();

        // R1/R2: all sharers start private.
        for (int s = 0; s < NS; s++) begin op_req(s, 0, 0); op_req(s, 1, 0); end
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R11 one-cycle strobe", int'(dec_valid), 0);

        // R6/R7/R10 sweep over sharers, reported counts and ack kinds.
        for (int s = 0; s < NS; s++)
            for (int u = 0; u < 8; u++)
                for (int ev = 0; ev < 2; ev++) begin
                    op_fill();
                    op_ack(s, u, ev[0]);
                    op_ack(s, 7 - u, ev[0]);
                end

        // R4 at level 0: promotion on the fourth access.
        op_fill(); op_ack(1, 0, 0);
        for (int k = 0; k < 4; k++) op_req(1, 0, 0);
        // R4/R7 at level 1: sixteen accesses, then level saturates.
        op_fill(); op_ack(2, 1, 1);
        for (int k = 0; k < 16; k++) op_req(2, k[0], 0);
        op_ack(2, 0, 1); op_ack(2, 9, 0);
        // R5: invalid way promotes at PCT despite level 1.
        for (int k = 0; k < 3; k++) op_req(2, 0, 0);
        op_req(2, 0, 1);

        // R8: write by another sharer clears counters; peek via remote ack (R10).
        op_fill();
        for (int s = 0; s < 3; s++) op_ack(s, 0, 0);
        op_req(0, 0, 0); op_req(0, 0, 0); op_req(1, 0, 0);
        op_req(2, 1, 0);
        op_ack(0, 0, 0); op_ack(1, 0, 0);
        op_req(1, 0, 0); op_req(3, 1, 0); op_ack(1, 0, 0);

        // R12: fill beats request, request beats ack.
        op_ack(0, 0, 1);
        cyc(1, 1, 0, 1, 0, 0, 0, 0, 0);
        model_fill();
        check("R12 fill over request", int'(dec_valid), 0);
        op_ack(3, 0, 0);
        cyc(0, 1, 3, 0, 0, 1, 0, 1, 0);
        model_req(3, 0, 0, exp, tag);
        check("R12 request over ack", dut_pk(), exp);
        op_req(0, 0, 0);

        // Mixed traffic against the model.
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 2) op_fill();
            else if (r < 70) op_req(int'($urandom_range(0, 3)), r < 15, r > 60);
            else op_ack(int'($urandom_range(0, 3)), int'($urandom_range(0, 6)), r[0]);
        end

        // R9: counter saturates at 15 in the copy whose top threshold is 40.
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 1, 0);
        check("R7 sat copy demote to level 1",
              pk(int'(s_valid), int'(s_grant), 0, int'(s_mode), int'(s_rutil), int'(s_lvl)),
              pk(1, 0, 0, 1, 0, 1));
        for (int k = 1; k <= 20; k++) begin
            cyc(0, 1, 0, 0, 0, 0, 0, 0, 0);
            check("R9 saturating counter",
                  pk(int'(s_valid), int'(s_grant), 0, int'(s_mode), int'(s_rutil), int'(s_lvl)),
                  pk(1, 1, 0, 1, (k > UMAX) ? UMAX : k, 1));
        end
        cyc(0, 1, 0, 0, 1, 0, 0, 0, 0);
        check("R5 sat copy invalid-way promote",
              pk(int'(s_valid), int'(s_grant), 0, int'(s_mode), int'(s_rutil), int'(s_lvl)),
              pk(1, 2, 0, 0, 0, 1));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule